// File: doc/BRIEF.md
# Signed Add/Subtract Unit with Overflow Handling

This block does arithmetic on two W-bit two's complement operands. A two-bit select picks one of four operations: add, subtract, negate A, and compare. The compare operation also yields A-B. All four run through one carry chain. Subtraction and negation become additions of an inverted operand with a carry-in of one, so the unit needs only one adder.

Each result carries four pieces of status. The first is the unsigned carry out of the top bit. The second is a signed overflow flag. The third is a signed wraparound error term: the true mathematical value minus the W-bit value the adder produced. The fourth is a greater-than flag that stays correct even when the subtraction behind it overflows.

A mode input chooses between wrapping and saturating. In saturate mode an overflowed result is clamped to the nearest end of the signed range. The datapath is combinational. A parameter can add one output register stage, and with it the outputs appear one clock after the inputs.

Top module: `sat_addsub_unit`

## Requirements
- R1: The select `op` is decoded as 00 add (A+B), 01 subtract (A-B), 10 negate (-A) and 11 compare (result holds A-B). With `sat_en` low, `result` is the true value reduced modulo 2^W into the signed range.
- R2: `ovf` is high exactly when the two adder operands share a sign bit and the sum's sign bit differs from it. Adder operands of opposite sign never raise `ovf`. For subtract and compare, the second adder operand is the inverted B with a carry-in of 1.
- R3: The sign-based overflow equals the XOR of the carry into the sign bit and the carry out of it, for every input.
- R4: Negating the most negative value (1 followed by W-1 zeros) returns that same pattern in wrap mode and raises `ovf`.
- R5: `wrap_err` equals (carry into sign bit minus carry out of sign bit) times 2^W. That is +2^W for an overflow with a non-negative first operand, -2^W for an overflow with a negative first operand, and 0 without overflow.
- R6: With `sat_en` high, positive overflow gives the largest positive value (0 followed by ones) and negative overflow gives the most negative value. Results that do not overflow pass through unchanged. `ovf` and `wrap_err` are reported the same way in both modes.
- R7: `carry_out` is the unsigned carry out of bit W-1 of the adder. It is 1 for an add whose unsigned sum reaches 2^W, 1 for a subtract or compare when unsigned A >= unsigned B, and 1 for negate only when A is zero. It has no effect on saturation.
- R8: For ops 01 and 11, `a_gt_b` is 1 exactly when signed A > signed B, including when A-B overflows. For ops 00 and 10 it is 0.
- R9: With `REG_OUT` set, all outputs appear one clock after their inputs, and while `rst_n` is low all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| a | input | W | Operand A, two's complement |
| b | input | W | Operand B, two's complement |
| op | input | 2 | Operation select: 00 add, 01 sub, 10 negate, 11 compare |
| sat_en | input | 1 | 1 = saturate on overflow, 0 = wrap |
| result | output | W | Arithmetic result |
| carry_out | output | 1 | Unsigned carry out of the adder |
| ovf | output | 1 | Signed overflow flag |
| wrap_err | output | W+2 | Signed wraparound error: true value minus wrapped value |
| a_gt_b | output | 1 | Signed A greater than B (ops 01 and 11) |

## Verification
On every cycle, the assertions check the agreement between the sign-based and carry-based overflow detectors, that operands of opposite sign never overflow, the negate-minimum case, the sign and zero condition of the error term, and which clamp constant saturation selects. Other behaviour only the bench's scenarios can show, because it is judged against a reference model built from integer arithmetic. This covers the exact wrapped values, the unsigned carry rules for each operation, the corrected compare at the edges of the range, and the one-cycle latency and reset state of the output stage.

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        a,
  input  logic [W-1:0]        b,
  input  logic [1:0]          op,
  input  logic                sat_en,
  output logic [W-1:0]        result,
  output logic                carry_out,
  output logic                ovf,
  output logic signed [W+1:0] wrap_err,
  output logic                a_gt_b
);
  localparam logic [W-1:0] MAXV   = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV   = {1'b1, {(W-1){1'b0}}};
  localparam logic [1:0]   OP_ADD = 2'b00;
  localparam logic [1:0]   OP_SUB = 2'b01;
  localparam logic [1:0]   OP_NEG = 2'b10;
  localparam logic [1:0]   OP_CMP = 2'b11;
  localparam logic signed [W+1:0] ERR_POS = {2'b01, {W{1'b0}}};
  localparam logic signed [W+1:0] ERR_NEG = {2'b11, {W{1'b0}}};

  logic [W-1:0] opx, opy;
  logic         cin;

  always_comb begin
    unique case (op)
      OP_ADD:  begin opx = a;          opy = b;  cin = 1'b0; end
      OP_NEG:  begin opx = '0;         opy = ~a; cin = 1'b1; end
      default: begin opx = a;          opy = ~b; cin = 1'b1; end
    endcase
  end

  logic [W-1:0] low_sum;
  logic [W:0]   full_sum;
  logic [W-1:0] raw;
  logic         c_into_sign, c_out_sign;
  logic         ovf_by_sign, ovf_by_carry, pos_ovf, is_diff;

  assign low_sum      = {1'b0, opx[W-2:0]} + {1'b0, opy[W-2:0]} + {{(W-1){1'b0}}, cin};
  assign full_sum     = {1'b0, opx} + {1'b0, opy} + {{W{1'b0}}, cin};
  assign raw          = full_sum[W-1:0];
  assign c_into_sign  = low_sum[W-1];
  assign c_out_sign   = full_sum[W];
  assign ovf_by_sign  = (opx[W-1] == opy[W-1]) && (raw[W-1] != opx[W-1]);
  assign ovf_by_carry = c_into_sign ^ c_out_sign;
  assign pos_ovf      = ovf_by_sign & ~opx[W-1];
  assign is_diff      = (op == OP_SUB) || (op == OP_CMP);

  logic [W-1:0]        res_c;
  logic signed [W+1:0] err_c;
  logic                gt_c;

  assign res_c = (sat_en && ovf_by_sign) ? (pos_ovf ? MAXV : MINV) : raw;
  assign err_c = (c_into_sign && !c_out_sign) ? ERR_POS :
                 (!c_into_sign && c_out_sign) ? ERR_NEG : '0;
  assign gt_c  = is_diff && !(raw[W-1] ^ ovf_by_sign) && (raw != '0);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result    <= '0;
          carry_out <= 1'b0;
          ovf       <= 1'b0;
          wrap_err  <= '0;
          a_gt_b    <= 1'b0;
        end else begin
          result    <= res_c;
          carry_out <= c_out_sign;
          ovf       <= ovf_by_sign;
          wrap_err  <= err_c;
          a_gt_b    <= gt_c;
        end
      end
    end else begin : g_comb
      assign result    = res_c;
      assign carry_out = c_out_sign;
      assign ovf       = ovf_by_sign;
      assign wrap_err  = err_c;
      assign a_gt_b    = gt_c;
    end
  endgenerate
endmodule

module addsub_checks #(
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [W-1:0]        a,
  input logic [1:0]          op,
  input logic                sat_en,
  input logic                x_sign,
  input logic                y_sign,
  input logic                ovf_s,
  input logic                ovf_k,
  input logic [W-1:0]        res_c,
  input logic signed [W+1:0] err_c
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // R3
  ovf_methods_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_s == ovf_k);

  // R2
  mixed_sign_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_sign != y_sign) |-> !ovf_s);

  // R4
  neg_min_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b10 && a == MINV) |-> (ovf_s && res_c == (sat_en ? MAXV : MINV)));

  // R5
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_s |-> (err_c == '0));

  // R5
  err_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_s |-> (err_c != '0 && err_c[W+1] == x_sign));

  // R6
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_en && ovf_s) |-> (res_c == (x_sign ? MINV : MAXV)));
endmodule

bind sat_addsub_unit addsub_checks #(.W(W)) u_addsub_checks (
  .clk    (clk),
  .rst_n  (rst_n),
  .a      (a),
  .op     (op),
  .sat_en (sat_en),
  .x_sign (opx[W-1]),
  .y_sign (opy[W-1]),
  .ovf_s  (ovf_by_sign),
  .ovf_k  (ovf_by_carry),
  .res_c  (res_c),
  .err_c  (err_c)
);

// File: tb/test_sat_addsub_unit.sv
module test_sat_addsub_unit;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [1:0] op = 2'b00;
  logic sat_en = 1'b0;
  logic [W-1:0] result;
  logic carry_out, ovf, a_gt_b;
  logic signed [W+1:0] wrap_err;

  always #2 clk = ~clk;

  sat_addsub_unit #(.W(W), .REG_OUT(1'b1)) i_sat_addsub_unit (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .sat_en(sat_en),
    .result(result), .carry_out(carry_out), .ovf(ovf),
    .wrap_err(wrap_err), .a_gt_b(a_gt_b)
  );

  typedef struct {
    int    r;
    bit    c;
    bit    v;
    int    e;
    bit    g;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic drive(input int av, input int bv, input logic [1:0] o,
                       input bit s, input string tag);
    exp_t x;
    int t, w, ua, ub, csum;
    ua = av & 255;
    ub = bv & 255;
    case (o)
      2'b00: begin t = av + bv; csum = ua + ub; end
      2'b10: begin t = -av;     csum = ((~ua) & 255) + 1; end
      default: begin t = av - bv; csum = ua + ((~ub) & 255) + 1; end
    endcase
    w = t;
    if (w > 127)  w -= 256;
    if (w < -128) w += 256;
    x.v = (t != w);
    x.e = t - w;
    x.r = (s && x.v) ? ((t > 0) ? 127 : -128) : w;
    x.c = (csum >= 256);
    x.g = (o == 2'b01 || o == 2'b11) ? (av > bv) : 1'b0;
    x.tag = tag;
    @(negedge clk);
    a = W'(av);
    b = W'(bv);
    op = o;
    sat_en = s;
    q.push_back(x);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        n_cmp++;
        if ($signed(result) != x.r || carry_out != x.c || ovf != x.v ||
            int'(wrap_err) != x.e || a_gt_b != x.g) begin
          n_bad++;
          $display("FAIL %s: got r=%0d c=%0b v=%0b e=%0d g=%0b exp r=%0d c=%0b v=%0b e=%0d g=%0b",
                   x.tag, $signed(result), carry_out, ovf, int'(wrap_err), a_gt_b,
                   x.r, x.c, x.v, x.e, x.g);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    // R9 reset state
    if (result != '0 || carry_out || ovf || wrap_err != '0 || a_gt_b) begin
      n_bad++;
      $display("FAIL R9: got r=%0d c=%0b v=%0b e=%0d g=%0b exp all zero",
               result, carry_out, ovf, int'(wrap_err), a_gt_b);
    end
    rst_n = 1'b1;

    drive(20, 30, 2'b00, 0, "R1");
    drive(20, 30, 2'b01, 0, "R1");
    drive(5, 0, 2'b10, 0, "R1");
    drive(-1, 1, 2'b00, 0, "R7");
    drive(100, 50, 2'b00, 0, "R2");
    drive(-100, -50, 2'b00, 0, "R2");
    drive(127, -128, 2'b00, 0, "R2");
    drive(-128, 0, 2'b10, 0, "R4");
    drive(-128, 0, 2'b10, 1, "R4");
    drive(0, 0, 2'b10, 0, "R7");
    drive(100, 50, 2'b00, 1, "R6");
    drive(-100, -50, 2'b00, 1, "R6");
    drive(100, -50, 2'b01, 1, "R6");
    drive(30, 40, 2'b00, 1, "R6");
    drive(-56, -56, 2'b00, 1, "R7");
    drive(-128, -128, 2'b00, 0, "R5");
    drive(100, -50, 2'b11, 0, "R8");
    drive(-50, 100, 2'b11, 0, "R8");
    drive(7, 7, 2'b11, 0, "R8");
    drive(-128, 127, 2'b11, 0, "R8");
    drive(127, -128, 2'b11, 1, "R8");
    drive(100, -50, 2'b00, 0, "R8");
    for (int i = -128; i < 128; i += 17)
      for (int j = -128; j < 128; j += 13)
        for (int k = 0; k < 8; k++)
          drive(i, j, k[1:0], k[2], "R1");
    repeat (4) @(negedge clk);
    // R9 reset clears registered outputs
    rst_n = 1'b0;
    #1;
    n_cmp++;
    if (result != '0 || carry_out || ovf || wrap_err != '0 || a_gt_b) begin
      n_bad++;
      $display("FAIL R9: got r=%0d c=%0b v=%0b e=%0d g=%0b exp all zero",
               result, carry_out, ovf, int'(wrap_err), a_gt_b);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule